// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Break Detection

This block turns an asynchronous serial line into parallel characters. The line is sampled only on clock cycles where a sample-tick enable is high. The tick runs at 1, 16 or 64 times the bit rate. A falling edge starts a character. In the two oversampled rates the start bit is checked again at its centre, so a short low glitch is rejected. Data bits arrive least significant bit first and are sampled at their centres. An optional parity bit and one stop bit follow the data. The finished character is placed in a holding register, right-aligned, and a ready flag is raised.

Parity, framing and overrun errors are recorded as sticky flags. These flags never stop reception. A separate detector raises a break flag when the line has stayed low for two whole character frames. After reset the receiver will not look for start bits until it has seen the line high at least once. A line left low after reset therefore produces no characters.

The receive state machine has six states. ARM waits for the first high sample after reset. HUNT looks for a falling edge. START waits to the start-bit centre. DATA collects the data bits. PAR takes the parity bit. STOP takes the stop bit.

Its transitions are:
- ARM to HUNT when a tick sees the line high.
- HUNT to START on an edge at 16x or 64x, or HUNT to DATA on an edge at 1x.
- START to HUNT when the centre sample is high (abort), or START to DATA when it is low.
- DATA to PAR or DATA to STOP after the last data bit.
- PAR to STOP after the parity bit.
- STOP to HUNT after the stop sample.

Top module: `serial_rx`

## Requirements
- R1: After reset the receiver ignores falling edges until one tick has sampled `rxd` high. This arming happens once per reset. A line held low from reset produces no character and no error.
- R2: A start begins on a tick where `rxd` is low and the previous tick sample was high. At 16x and 64x the line is sampled again N/2 ticks later, where N is the tick rate. If that sample is high, the character is abandoned and nothing is delivered.
- R3: `rate_sel` selects the tick rate: 00 is 1x, 01 is 16x, 10 and 11 are 64x. The start edge is tick offset 0 and H = N/2 (0 at 1x). Frame bit j (0 = start) is sampled at tick offset H + j·N. Data bits arrive least significant bit first. `len_sel` 00/01/10/11 selects 5/6/7/8 data bits.
- R4: `rx_data` holds the character right-aligned. Bits above the programmed length read 0, and the parity bit never appears in `rx_data`.
- R5: When `par_en` is 1, a parity bit follows the data. `par_even` = 1 means the data bits plus the parity bit hold an even number of ones; 0 means odd. A mismatch sets `par_err`.
- R6: Only one stop bit is sampled. If it is low, `frm_err` is set. The next start can be detected from the following tick.
- R7: With `rx_en` high, a completed character loads `rx_data` and sets `rx_ready` at the clock edge of the stop sample. A `rd_stb` pulse clears `rx_ready`.
- R8: If a character completes while `rx_ready` is set, `ovr_err` is set and the new character replaces the old one. This includes the case where `rd_stb` falls on the same clock as the completion.
- R9: While `rx_en` is low, `rx_ready` is cleared on the next clock. A character completing during that time is dropped: `rx_data` and all flags are left unchanged.
- R10: `brk_det` is set on the tick that makes the run of consecutive low samples reach 2·(2 + length + parity)·N. It clears on the first tick that samples `rxd` high, or on reset.
- R11: `par_err`, `frm_err` and `ovr_err` stay set until `err_clr`. If a new error arrives on the same clock as `err_clr`, the error wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_tick | input | 1 | Sample-tick enable at N times the bit rate |
| rate_sel | input | 2 | Tick rate select (00 1x, 01 16x, 1x 64x) |
| len_sel | input | 2 | Data length select (5 + value bits) |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| rx_en | input | 1 | Receive enable |
| rxd | input | 1 | Serial line, idle high |
| rd_stb | input | 1 | One-clock read of the holding register |
| err_clr | input | 1 | Clear parity, framing and overrun flags |
| rx_data | output | 8 | Received character, right-aligned |
| rx_ready | output | 1 | Holding register has an unread character |
| par_err | output | 1 | Sticky parity error |
| frm_err | output | 1 | Sticky framing error |
| ovr_err | output | 1 | Sticky overrun error |
| brk_det | output | 1 | Line break present |

## Verification
The hardest situation to reach is the overrun where a read lands on the exact clock the stop bit is sampled. The stimulus reaches it by counting ticks inside each frame it sends. It asserts `rd_stb` on the tick at offset N/2 within the stop bit, while an earlier character is still unread. The arming rule is exercised by holding the line low for longer than one full frame straight after reset. The break detector is exercised by holding the line low across two full frames. The reference model tracks the tick offset of every sample, so both conditions are checked on every clock.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    // Receive framing states
    typedef enum logic [2:0] {
        S_ARM,
        S_HUNT,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } rx_state_e;

    // Holding register occupancy
    typedef enum logic {
        H_EMPTY,
        H_FULL
    } hold_state_e;

    // Line condition seen by the break detector
    typedef enum logic {
        L_CLEAR,
        L_BREAK
    } line_state_e;

    localparam logic [1:0] RATE_1X  = 2'b00;
    localparam logic [1:0] RATE_MID = 2'b01;

endpackage

// File: rtl/serial_rx_fsm.sv
module serial_rx_fsm
    import serial_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TPB_W  = 7,
    parameter int CNT_W  = 6,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rxd,
    input  logic [TPB_W-1:0]  tpb,
    input  logic [LEN_W-1:0]  char_len,
    input  logic              par_en,
    input  logic              par_even,
    output logic              xfer,
    output logic [DATA_W-1:0] char_val,
    output logic              perr,
    output logic              ferr
);

    rx_state_e         state_q;
    rx_state_e         state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [LEN_W-1:0]  nbits_q;
    logic [DATA_W-1:0] shreg_q;
    logic              acc_q;
    logic              pbad_q;
    logic              prev_q;

    logic              one_x;
    logic [CNT_W-1:0]  full_ld;
    logic [CNT_W-1:0]  half_ld;
    logic              at_centre;
    logic              edge_seen;
    logic              last_data;

    assign one_x     = (tpb == TPB_W'(1));
    assign full_ld   = CNT_W'(tpb - TPB_W'(1));
    assign half_ld   = CNT_W'((tpb >> 1) - TPB_W'(1));
    assign at_centre = tick && (cnt_q == '0);
    assign edge_seen = tick && prev_q && !rxd;
    assign last_data = (nbits_q == (char_len - LEN_W'(1)));

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_ARM;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_ARM:   if (tick && rxd) state_d = S_HUNT;
            S_HUNT:  if (edge_seen)   state_d = one_x ? S_DATA : S_START;
            S_START: if (at_centre)   state_d = rxd ? S_HUNT : S_DATA;
            S_DATA:  if (at_centre && last_data) state_d = par_en ? S_PAR : S_STOP;
            S_PAR:   if (at_centre)   state_d = S_STOP;
            S_STOP:  if (at_centre)   state_d = S_HUNT;
            default: state_d = S_ARM;
        endcase
    end

    // Bit timing and character assembly
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b1;
            cnt_q   <= '0;
            nbits_q <= '0;
            shreg_q <= '0;
            acc_q   <= 1'b0;
            pbad_q  <= 1'b0;
        end else if (tick) begin
            prev_q <= rxd;
            cnt_q  <= (cnt_q == '0) ? full_ld : cnt_q - CNT_W'(1);
            unique case (state_q)
                S_HUNT: begin
                    if (edge_seen) begin
                        cnt_q   <= one_x ? '0 : half_ld;
                        nbits_q <= '0;
                        acc_q   <= 1'b0;
                        pbad_q  <= 1'b0;
                    end
                end
                S_DATA: begin
                    if (at_centre) begin
                        shreg_q <= {rxd, shreg_q[DATA_W-1:1]};
                        acc_q   <= acc_q ^ rxd;
                        nbits_q <= nbits_q + LEN_W'(1);
                    end
                end
                S_PAR: begin
                    if (at_centre) pbad_q <= acc_q ^ rxd ^ !par_even;
                end
                default: ;
            endcase
        end
    end

    // Outputs toward the holding register
    always_comb begin
        xfer     = (state_q == S_STOP) && at_centre;
        char_val = shreg_q >> (DATA_W - int'(char_len));
        perr     = par_en && pbad_q;
        ferr     = !rxd;
    end

    // R1
    arm_once_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != S_ARM) |=> (state_q != S_ARM));

    // R2
    start_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_START && at_centre && rxd) |=> (state_q == S_HUNT && !xfer));

endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold
    import serial_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              rd_stb,
    input  logic              err_clr,
    input  logic              xfer,
    input  logic [DATA_W-1:0] char_val,
    input  logic              perr,
    input  logic              ferr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              par_err,
    output logic              frm_err,
    output logic              ovr_err
);

    hold_state_e       hst_q;
    hold_state_e       hst_d;
    logic [DATA_W-1:0] data_q;
    logic              pe_q;
    logic              fe_q;
    logic              oe_q;
    logic              take;

    assign take = rx_en && xfer;

    always_ff @(posedge clk) begin
        if (rst) begin
            hst_q <= H_EMPTY;
        end else begin
            hst_q <= hst_d;
        end
    end

    always_comb begin
        hst_d = hst_q;
        unique case (hst_q)
            H_EMPTY: if (take) hst_d = H_FULL;
            H_FULL:  if (!rx_en || (rd_stb && !xfer)) hst_d = H_EMPTY;
            default: hst_d = H_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            pe_q   <= 1'b0;
            fe_q   <= 1'b0;
            oe_q   <= 1'b0;
        end else begin
            if (take) data_q <= char_val;
            pe_q <= (pe_q && !err_clr) || (take && perr);
            fe_q <= (fe_q && !err_clr) || (take && ferr);
            oe_q <= (oe_q && !err_clr) || (take && (hst_q == H_FULL));
        end
    end

    always_comb begin
        rx_data  = data_q;
        rx_ready = (hst_q == H_FULL);
        par_err  = pe_q;
        frm_err  = fe_q;
        ovr_err  = oe_q;
    end

    // R9
    ready_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !rx_ready);

    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (take && rx_ready) |=> (ovr_err && rx_ready));

    // R6
    frame_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (take && ferr) |=> frm_err);

    // R11
    sticky_ovr_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr_err && !err_clr) |=> ovr_err);

endmodule

// File: rtl/serial_rx_brk.sv
module serial_rx_brk
    import serial_rx_pkg::*;
#(
    parameter int BRK_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             rxd,
    input  logic [BRK_W-1:0] brk_thr,
    output logic             brk_det
);

    localparam logic [BRK_W-1:0] LOW_SAT = '1;

    line_state_e      lst_q;
    line_state_e      lst_d;
    logic [BRK_W-1:0] low_q;
    logic [BRK_W:0]   low_next;

    assign low_next = {1'b0, low_q} + (BRK_W+1)'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            lst_q <= L_CLEAR;
        end else begin
            lst_q <= lst_d;
        end
    end

    always_comb begin
        lst_d = lst_q;
        unique case (lst_q)
            L_CLEAR: if (tick && !rxd && (low_next >= {1'b0, brk_thr})) lst_d = L_BREAK;
            L_BREAK: if (tick && rxd) lst_d = L_CLEAR;
            default: lst_d = L_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q <= '0;
        end else if (tick) begin
            if (rxd) begin
                low_q <= '0;
            end else if (low_q != LOW_SAT) begin
                low_q <= low_q + BRK_W'(1);
            end
        end
    end

    assign brk_det = (lst_q == L_BREAK);

    // R10
    brk_release_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && rxd) |=> !brk_det);

    // R10
    brk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (brk_det && !(tick && rxd)) |=> brk_det);

endmodule

// File: rtl/serial_rx.sv
module serial_rx
    import serial_rx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int MIN_LEN = 5,
    parameter int OS_MID  = 16,
    parameter int OS_HI   = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              samp_tick,
    input  logic [1:0]        rate_sel,
    input  logic [1:0]        len_sel,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              rx_en,
    input  logic              rxd,
    input  logic              rd_stb,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              par_err,
    output logic              frm_err,
    output logic              ovr_err,
    output logic              brk_det
);

    localparam int TPB_W   = $clog2(OS_HI + 1);
    localparam int CNT_W   = $clog2(OS_HI);
    localparam int LEN_W   = $clog2(DATA_W + 1);
    localparam int BRK_MAX = 2 * (DATA_W + 3) * OS_HI;
    localparam int BRK_W   = $clog2(BRK_MAX + 1);

    logic [TPB_W-1:0]  tpb;
    logic [LEN_W-1:0]  char_len;
    logic [BRK_W-1:0]  brk_thr;
    logic              xfer;
    logic [DATA_W-1:0] char_val;
    logic              perr;
    logic              ferr;

    always_comb begin
        unique case (rate_sel)
            RATE_1X:  tpb = TPB_W'(1);
            RATE_MID: tpb = TPB_W'(OS_MID);
            default:  tpb = TPB_W'(OS_HI);
        endcase
    end

    assign char_len = LEN_W'(MIN_LEN) + LEN_W'(len_sel);
    assign brk_thr  = BRK_W'(2) * (BRK_W'(2) + BRK_W'(char_len) + BRK_W'(par_en)) * BRK_W'(tpb);

    serial_rx_fsm #(
        .DATA_W (DATA_W),
        .TPB_W  (TPB_W),
        .CNT_W  (CNT_W),
        .LEN_W  (LEN_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tick     (samp_tick),
        .rxd      (rxd),
        .tpb      (tpb),
        .char_len (char_len),
        .par_en   (par_en),
        .par_even (par_even),
        .xfer     (xfer),
        .char_val (char_val),
        .perr     (perr),
        .ferr     (ferr)
    );

    serial_rx_hold #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk      (clk),
        .rst      (rst),
        .rx_en    (rx_en),
        .rd_stb   (rd_stb),
        .err_clr  (err_clr),
        .xfer     (xfer),
        .char_val (char_val),
        .perr     (perr),
        .ferr     (ferr),
        .rx_data  (rx_data),
        .rx_ready (rx_ready),
        .par_err  (par_err),
        .frm_err  (frm_err),
        .ovr_err  (ovr_err)
    );

    serial_rx_brk #(
        .BRK_W (BRK_W)
    ) u_brk (
        .clk     (clk),
        .rst     (rst),
        .tick    (samp_tick),
        .rxd     (rxd),
        .brk_thr (brk_thr),
        .brk_det (brk_det)
    );

endmodule

// File: tb/serial_rx_bench.sv
module serial_rx_bench;

    localparam int CLK_NS = 10;

    logic       clk      = 1'b0;
    logic       rst      = 1'b1;
    logic       tick     = 1'b0;
    logic [1:0] rate_sel = 2'b01;
    logic [1:0] len_sel  = 2'b11;
    logic       par_en   = 1'b0;
    logic       par_even = 1'b0;
    logic       rx_en    = 1'b0;
    logic       rxd      = 1'b0;
    logic       rd_stb   = 1'b0;
    logic       err_clr  = 1'b0;

    logic [7:0] rx_data;
    logic       rx_ready, par_err, frm_err, ovr_err, brk_det;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    always #(CLK_NS/2) clk = ~clk;

    serial_rx u_serial_rx (
        .clk(clk), .rst(rst), .samp_tick(tick), .rate_sel(rate_sel), .len_sel(len_sel),
        .par_en(par_en), .par_even(par_even), .rx_en(rx_en), .rxd(rxd), .rd_stb(rd_stb),
        .err_clr(err_clr), .rx_data(rx_data), .rx_ready(rx_ready), .par_err(par_err),
        .frm_err(frm_err), .ovr_err(ovr_err), .brk_det(brk_det)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_arm, m_act, m_prev, m_brk, m_rdy, m_pe, m_fe, m_oe;
    int m_off, m_val, m_ones, m_low, m_data;

    always @(posedge clk) begin
        bit done, pbad, fbad;
        int n, len, p, h, j, val;
        done = 0; pbad = 0; fbad = 0; val = 0;
        if (rst) begin
            m_arm = 0; m_act = 0; m_prev = 1; m_brk = 0; m_rdy = 0;
            m_pe = 0; m_fe = 0; m_oe = 0; m_low = 0; m_data = 0; m_off = 0;
        end else begin
            if (tick) begin
                n   = (rate_sel == 2'b00) ? 1 : (rate_sel == 2'b01) ? 16 : 64;
                len = 5 + int'(len_sel);
                p   = par_en ? 1 : 0;
                h   = n / 2;
                if (rxd) begin
                    m_low = 0; m_brk = 0;
                end else begin
                    m_low++;
                    if (m_low >= 2 * (2 + len + p) * n) m_brk = 1;
                end
                if (!m_arm) begin
                    if (rxd) m_arm = 1;
                end else if (m_act) begin
                    m_off++;
                    if (m_off >= h && (m_off - h) % n == 0) begin
                        j = (m_off - h) / n;
                        if (j == 0) begin
                            if (rxd) m_act = 0;
                        end else if (j <= len) begin
                            m_val  = m_val | (int'(rxd) << (j - 1));
                            m_ones = m_ones + int'(rxd);
                        end else if (p == 1 && j == len + 1) begin
                            m_ones = m_ones + int'(rxd);
                        end else begin
                            done  = 1;
                            val   = m_val;
                            pbad  = (p == 1) && (par_even ? (m_ones % 2 == 1) : (m_ones % 2 == 0));
                            fbad  = !rxd;
                            m_act = 0;
                        end
                    end
                end else if (m_prev && !rxd) begin
                    m_act = 1; m_off = 0; m_val = 0; m_ones = 0;
                end
                m_prev = rxd;
            end
            if (err_clr) begin m_pe = 0; m_fe = 0; m_oe = 0; end
            if (!rx_en) begin
                m_rdy = 0;
            end else if (done) begin
                if (m_rdy) m_oe = 1;
                m_rdy  = 1;
                m_data = val;
                if (pbad) m_pe = 1;
                if (fbad) m_fe = 1;
            end else if (rd_stb) begin
                m_rdy = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !ended) begin
            check("R7 ready vs model",   rx_ready, m_rdy);
            check("R3 R4 data vs model", rx_data,  m_data);
            check("R5 parity vs model",  par_err,  m_pe);
            check("R6 framing vs model", frm_err,  m_fe);
            check("R8 overrun vs model", ovr_err,  m_oe);
            check("R10 break vs model",  brk_det,  m_brk);
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick_once(input logic line, input logic rd_now);
        @(negedge clk); rxd = line; tick = 1'b1; rd_stb = rd_now;
        @(negedge clk); tick = 1'b0; rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick_once(1'b1, 1'b0);
    endtask

    task automatic do_read();
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] r, input logic [1:0] l, input logic pe, input logic ev);
        @(negedge clk); rate_sel = r; len_sel = l; par_en = pe; par_even = ev;
    endtask

    task automatic send(input int val, input bit bad_par, input bit bad_stop, input bit rd_at_stop);
        logic bits [12];
        int n, len, ones, idx, nb;
        n    = (rate_sel == 2'b00) ? 1 : (rate_sel == 2'b01) ? 16 : 64;
        len  = 5 + int'(len_sel);
        ones = 0;
        bits[0] = 1'b0;
        for (int i = 0; i < len; i++) begin
            bits[1 + i] = logic'((val >> i) & 1);
            ones += (val >> i) & 1;
        end
        idx = len + 1;
        if (par_en) begin
            bits[idx] = par_even ? logic'(ones % 2) : logic'((ones + 1) % 2);
            if (bad_par) bits[idx] = !bits[idx];
            idx++;
        end
        bits[idx] = !bad_stop;
        nb = idx + 1;
        for (int j = 0; j < nb; j++)
            for (int k = 0; k < n; k++)
                tick_once(bits[j], logic'(rd_at_stop && j == nb - 1 && k == n / 2));
        idle(4);
    endtask

    task automatic finish_run();
        ended = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog R1..all actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R7 reset ready", rx_ready, 0);
        check("R4 reset data", rx_data, 0);
        check("R11 reset flags", {par_err, frm_err, ovr_err}, 0);
        check("R10 reset break", brk_det, 0);
        rx_en = 1'b1;

        // R1: line low from reset for longer than a frame
        for (int i = 0; i < 200; i++) tick_once(1'b0, 1'b0);
        idle(20);
        check("R1 no char while unarmed", rx_ready, 0);
        check("R1 no framing while unarmed", frm_err, 0);

        // R3: 16x, 8 bits, no parity
        send(8'hA5, 0, 0, 0);
        check("R3 16x 8-bit data", rx_data, 8'hA5);
        check("R7 ready set", rx_ready, 1);
        do_read();
        check("R7 ready cleared by read", rx_ready, 0);

        // R4 R5: 7 bits, even parity
        set_mode(2'b01, 2'b10, 1'b1, 1'b1);
        send(8'h35, 0, 0, 0);
        check("R4 7-bit right aligned", rx_data, 8'h35);
        check("R5 good parity", par_err, 0);
        do_read();
        send(8'h35, 1, 0, 0);
        check("R5 bad parity flagged", par_err, 1);
        do_read();
        do_clear();
        check("R11 err_clr clears parity", par_err, 0);

        // R3: 64x, 5 bits, odd parity
        set_mode(2'b10, 2'b00, 1'b1, 1'b0);
        send(8'h13, 0, 0, 0);
        check("R3 64x 5-bit data", rx_data, 8'h13);
        check("R5 odd parity ok", par_err, 0);
        do_read();

        // R3: 1x, 6 bits
        set_mode(2'b00, 2'b01, 1'b0, 1'b0);
        send(8'h2A, 0, 0, 0);
        check("R3 1x 6-bit data", rx_data, 8'h2A);
        do_read();

        // R6 R11: framing, then sticky across a good frame
        set_mode(2'b01, 2'b11, 1'b0, 1'b0);
        send(8'h3C, 0, 1, 0);
        check("R6 framing flagged", frm_err, 1);
        check("R6 data kept", rx_data, 8'h3C);
        do_read();
        send(8'h81, 0, 0, 0);
        check("R11 framing sticky", frm_err, 1);
        check("R6 next char after framing", rx_data, 8'h81);
        do_read();
        do_clear();

        // R8: overrun, unread
        send(8'h11, 0, 0, 0);
        send(8'h22, 0, 0, 0);
        check("R8 overrun flagged", ovr_err, 1);
        check("R8 newer char kept", rx_data, 8'h22);
        do_read();
        do_clear();
        check("R11 overrun cleared", ovr_err, 0);

        // R8: read on the stop-sample clock
        send(8'h44, 0, 0, 0);
        send(8'h55, 0, 0, 1);
        check("R8 coincident read overrun", ovr_err, 1);
        check("R8 ready after coincident read", rx_ready, 1);
        do_read();
        do_clear();

        // R2: short low glitch at 16x
        for (int i = 0; i < 4; i++) tick_once(1'b0, 1'b0);
        idle(30);
        check("R2 glitch gives no char", rx_ready, 0);
        check("R2 glitch keeps data", rx_data, 8'h55);
        send(8'h66, 0, 0, 0);
        check("R2 recovery char", rx_data, 8'h66);
        do_read();

        // R9: receive enable off
        send(8'h77, 0, 0, 0);
        @(negedge clk); rx_en = 1'b0;
        @(negedge clk);
        check("R9 ready cleared when disabled", rx_ready, 0);
        send(8'h99, 0, 1, 0);
        check("R9 char dropped when disabled", rx_data, 8'h77);
        check("R9 no flag when disabled", frm_err, 0);
        @(negedge clk); rx_en = 1'b1;

        // R10: break over two frames
        for (int i = 0; i < 330; i++) tick_once(1'b0, 1'b0);
        check("R10 break set", brk_det, 1);
        tick_once(1'b1, 1'b0);
        check("R10 break released", brk_det, 0);
        idle(10);
        do_read();
        do_clear();
        idle(5);

        finish_run();
    end

endmodule